// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide host-side register file of a three-channel interval timer. A 2-bit address selects one of three channel data ports (0 to 2) or the control port (3). Through the control port the host programs each channel's counting mode, its BCD flag and its byte access pattern. It can also freeze a channel's running count for a later read, or issue a read-back command that freezes count and status for any group of channels in one write.

Data port writes are put together into 16-bit reload values. The block hands a reload value to its channel with a one-cycle load strobe. Data port reads return, in priority order, a frozen status byte, a frozen count, or the live count, one byte at a time in the programmed byte order. The counters themselves sit outside this block. They give it their live counts and output bits, and they take its load strobes, reload values and mode fields.

A read is a single-cycle `rd` pulse. `rdata` is combinational during that cycle, and the read's side effects (byte pointer advance, release of frozen data) take place at the closing clock edge. A write is a single-cycle `wr` pulse that is acted on at the clock edge. When `wr` and `rd` are asserted together, the write wins and the read is dropped.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel has access type low-then-high (code 11), mode 3, BCD 0, no frozen count, no frozen status and both byte pointers on the low byte, and no load strobe is raised.
- R2: A control write (address 3) uses bits 7:6 to pick channel 0, 1 or 2. When bits 5:4 are not 00, it sets that channel's access type from bits 5:4, its mode from bits 3:1 and its BCD flag from bit 0, and it returns both of the channel's byte pointers to the low byte, so a half-finished low/high sequence is dropped.
- R3: With access type 01 (low only), a data write of byte b raises that channel's load strobe for exactly one cycle, in the cycle after the write, with reload value {8'h00, b}. With access type 10 (high only), the reload value is {b, 8'h00}.
- R4: With access type 11, the first data write is held and raises no strobe. The second write raises the strobe in the following cycle with reload {second, first}, and the next write counts as a first write again.
- R5: A control write with bits 5:4 = 00 freezes the selected channel's live count. While an earlier frozen count has not been fully read, further freeze requests for that channel are ignored.
- R6: A frozen count is read out in the channel's access order: low only, high only, or low then high. It is released after its last byte, and later reads return the live count.
- R7: A control write with bits 7:6 = 11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 freezes the count and bit 4 = 0 freezes the status of every selected channel in the same cycle.
- R8: The status byte is {output bit, 0, access[1:0], mode[2:0], bcd}, captured at the read-back edge. A new status request is ignored while an earlier status byte is still unread.
- R9: When both are pending, a read returns the frozen status byte first and leaves the frozen count untouched for the following reads.
- R10: With nothing frozen, reads return the live count: the low byte for access 01, the high byte for access 10, and for access 11 alternately the low and then the high byte, starting with the low byte.
- R11: A read of address 3 returns 8'hFF and changes no state. When no read is in progress, rdata is 8'h00.
- R12: Each channel's mode output always shows the mode last programmed for it (3 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 to 2 channel data ports, 3 control port |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe, one cycle per byte |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid during the rd cycle |
| cnt_live | input | 48 | Live 16-bit count of each channel, channel 0 in bits 15:0 |
| cnt_out | input | 3 | Output bit of each channel |
| ld_stb | output | 3 | One-cycle reload strobe for each channel |
| ld_val | output | 48 | 16-bit reload value for each channel, valid with its strobe |
| ch_mode | output | 9 | 3-bit programmed mode for each channel, channel 0 in bits 2:0 |

## Verification
Every cycle, the assertions check the following. A load strobe only follows a data write, and only one strobe is raised at a time. A frozen count holds still while it is pending. A pending status byte is not overwritten, and reading it leaves the frozen count alone. Programming a channel rewinds its byte pointers, and a control-port read returns 8'hFF. Other behaviour needs the bench's scenarios, which are compared cycle by cycle against a behavioural model. That covers the byte order of multi-byte writes and reads, ignored freeze requests that follow a changed live count, read-back across several channels at once, and the status-before-count ordering.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int NCH_D = 3;
    localparam int BW_D  = 8;
    localparam int CW_D  = 16;
    localparam int MW_D  = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    typedef struct packed {
        logic prog;
        logic latch_cnt;
        logic latch_sts;
        logic data_wr;
        logic data_rd;
    } chan_cmd_t;

    typedef struct packed {
        logic       out;
        logic       nullc;
        logic [1:0] acc;
        logic [2:0] mode;
        logic       bcd;
    } status_t;

    function automatic status_t make_status(logic o, acc_e a, logic [2:0] m, logic b);
        status_t s;
        s.out   = o;
        s.nullc = 1'b0;
        s.acc   = a;
        s.mode  = m;
        s.bcd   = b;
        return s;
    endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_regif_pkg::*;
#(
    parameter int NCH = NCH_D,
    parameter int BW  = BW_D
) (
    input  logic [1:0]                addr,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [BW-1:0]             wdata,
    output chan_cmd_t [NCH-1:0]       cmd
);

    logic ctl_wr;
    logic rb_cmd;

    assign ctl_wr = wr && (addr == 2'd3);
    assign rb_cmd = ctl_wr && (wdata[7:6] == 2'b11);

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cmd[i].prog      = ctl_wr && (wdata[7:6] == 2'(i)) && (wdata[5:4] != 2'b00);
            cmd[i].latch_cnt = (ctl_wr && (wdata[7:6] == 2'(i)) && (wdata[5:4] == 2'b00))
                             || (rb_cmd && wdata[i+1] && !wdata[5]);
            cmd[i].latch_sts = rb_cmd && wdata[i+1] && !wdata[4];
            cmd[i].data_wr   = wr && (addr == 2'(i));
            cmd[i].data_rd   = rd && !wr && (addr == 2'(i));
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regif_pkg::*;
#(
    parameter int BW = BW_D,
    parameter int CW = CW_D,
    parameter int MW = MW_D
) (
    input  logic          clk,
    input  logic          rst,
    input  chan_cmd_t     cmd,
    input  logic [BW-1:0] wdata,
    input  logic [CW-1:0] cnt_live,
    input  logic          cnt_out,
    output logic          ld_stb,
    output logic [CW-1:0] ld_val,
    output logic [MW-1:0] mode,
    output logic [BW-1:0] rbyte
);

    acc_e          acc_q;
    logic          bcd_q;
    logic          wsel_hi;
    logic          rsel_hi;
    logic [BW-1:0] hold_q;
    logic [CW-1:0] lat_val;
    acc_e          lat_st;
    status_t       sts_q;
    logic          sts_pend;

    always_comb begin
        if (sts_pend)
            rbyte = BW'(sts_q);
        else if (lat_st != ACC_LATCH)
            rbyte = (lat_st == ACC_HI) ? lat_val[CW-1 -: BW] : lat_val[BW-1:0];
        else if (acc_q == ACC_HI || (acc_q == ACC_LOHI && rsel_hi))
            rbyte = cnt_live[CW-1 -: BW];
        else
            rbyte = cnt_live[BW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= ACC_LOHI;
            mode     <= MW'(3);
            bcd_q    <= 1'b0;
            wsel_hi  <= 1'b0;
            rsel_hi  <= 1'b0;
            hold_q   <= '0;
            lat_val  <= '0;
            lat_st   <= ACC_LATCH;
            sts_q    <= '0;
            sts_pend <= 1'b0;
            ld_stb   <= 1'b0;
            ld_val   <= '0;
        end else begin
            ld_stb <= 1'b0;
            if (cmd.prog) begin
                acc_q   <= acc_e'(wdata[5:4]);
                mode    <= wdata[3:1];
                bcd_q   <= wdata[0];
                wsel_hi <= 1'b0;
                rsel_hi <= 1'b0;
            end
            if (cmd.latch_cnt && lat_st == ACC_LATCH) begin
                lat_val <= cnt_live;
                lat_st  <= acc_q;
            end
            if (cmd.latch_sts && !sts_pend) begin
                sts_q    <= make_status(cnt_out, acc_q, mode, bcd_q);
                sts_pend <= 1'b1;
            end
            if (cmd.data_wr) begin
                unique case (acc_q)
                    ACC_HI: begin
                        ld_stb <= 1'b1;
                        ld_val <= CW'(wdata) << BW;
                    end
                    ACC_LOHI: begin
                        if (wsel_hi) begin
                            ld_stb  <= 1'b1;
                            ld_val  <= CW'({wdata, hold_q});
                            wsel_hi <= 1'b0;
                        end else begin
                            hold_q  <= wdata;
                            wsel_hi <= 1'b1;
                        end
                    end
                    default: begin
                        ld_stb <= 1'b1;
                        ld_val <= CW'(wdata);
                    end
                endcase
            end
            if (cmd.data_rd) begin
                if (sts_pend)
                    sts_pend <= 1'b0;
                else if (lat_st != ACC_LATCH)
                    lat_st <= (lat_st == ACC_LOHI) ? ACC_HI : ACC_LATCH;
                else if (acc_q == ACC_LOHI)
                    rsel_hi <= !rsel_hi;
            end
        end
    end

    AST_LOAD_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        ld_stb |-> $past(cmd.data_wr)) else $error("load strobe without write"); // R3

    AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (lat_st != ACC_LATCH) |=> $stable(lat_val)) else $error("frozen count moved"); // R5

    AST_STS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (sts_pend && cmd.latch_sts) |=> $stable(sts_q)) else $error("status overwritten"); // R8

    AST_STS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (sts_pend && cmd.data_rd) |=> (lat_st == $past(lat_st))) else $error("count consumed before status"); // R9

    AST_PROG_REWINDS: assert property (@(posedge clk) disable iff (rst)
        cmd.prog |=> (!wsel_hi && !rsel_hi)) else $error("pointers not rewound"); // R2

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int NCH = NCH_D,
    parameter int BW  = BW_D,
    parameter int CW  = CW_D,
    parameter int MW  = MW_D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         addr,
    input  logic               wr,
    input  logic               rd,
    input  logic [BW-1:0]      wdata,
    output logic [BW-1:0]      rdata,
    input  logic [NCH*CW-1:0]  cnt_live,
    input  logic [NCH-1:0]     cnt_out,
    output logic [NCH-1:0]     ld_stb,
    output logic [NCH*CW-1:0]  ld_val,
    output logic [NCH*MW-1:0]  ch_mode
);

    chan_cmd_t [NCH-1:0]         cmd;
    logic      [NCH-1:0][BW-1:0] rbyte;

    tmr_cmd_decode #(.NCH(NCH), .BW(BW)) u_dec (
        .addr  (addr),
        .wr    (wr),
        .rd    (rd),
        .wdata (wdata),
        .cmd   (cmd)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan_regs #(.BW(BW), .CW(CW), .MW(MW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cmd      (cmd[g]),
            .wdata    (wdata),
            .cnt_live (cnt_live[g*CW +: CW]),
            .cnt_out  (cnt_out[g]),
            .ld_stb   (ld_stb[g]),
            .ld_val   (ld_val[g*CW +: CW]),
            .mode     (ch_mode[g*MW +: MW]),
            .rbyte    (rbyte[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd && !wr) begin
            if (addr == 2'd3)
                rdata = '1;
            else
                for (int i = 0; i < NCH; i++)
                    if (addr == 2'(i))
                        rdata = rbyte[i];
        end
    end

    AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_stb)) else $error("more than one load strobe"); // R4

    AST_CTL_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr && addr == 2'd3) |-> (rdata == '1)) else $error("control read returned data"); // R11

endmodule

// File: tb/tmr_regif_tb.sv
`timescale 1ns/1ps
module tmr_regif_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] live [3];
    logic [47:0] cnt_live;
    logic [2:0]  cnt_out = '0;
    logic [2:0]  ld_stb;
    logic [47:0] ld_val;
    logic [8:0]  ch_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state
    int m_acc [3];
    int m_mode [3];
    int m_bcd [3];
    int m_wp [3];
    int m_rp [3];
    int m_hold [3];
    int m_lat [3];
    int m_lst [3];
    int m_sts [3];
    int m_sp [3];
    int e_stb [3];
    int e_val [3];

    always #4 clk = ~clk;

    assign cnt_live = {live[2], live[1], live[0]};

    tmr_regif u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
        .rdata(rdata), .cnt_live(cnt_live), .cnt_out(cnt_out),
        .ld_stb(ld_stb), .ld_val(ld_val), .ch_mode(ch_mode)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            m_acc[c] = 3; m_mode[c] = 3; m_bcd[c] = 0; m_wp[c] = 0; m_rp[c] = 0;
            m_hold[c] = 0; m_lat[c] = 0; m_lst[c] = 0; m_sts[c] = 0; m_sp[c] = 0;
            e_stb[c] = 0; e_val[c] = 0;
        end
    endtask

    function automatic int model_rdata(input int a, input int w, input int r);
        int v;
        if (r == 0 || w != 0) return 0;
        if (a == 3) return 255;
        if (m_sp[a] != 0) return m_sts[a];
        if (m_lst[a] != 0) return (m_lst[a] == 2) ? (m_lat[a] / 256) : (m_lat[a] % 256);
        v = int'(live[a]);
        if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rp[a] != 0)) return v / 256;
        return v % 256;
    endfunction

    task automatic model_freeze(input int c);
        if (m_lst[c] == 0) begin
            m_lat[c] = int'(live[c]);
            m_lst[c] = m_acc[c];
        end
    endtask

    task automatic model_step(input int a, input int w, input int r, input int d);
        for (int c = 0; c < 3; c++) e_stb[c] = 0;
        if (w != 0 && a == 3) begin
            if (d / 64 == 3) begin
                for (int c = 0; c < 3; c++) begin
                    if (((d >> (c + 1)) & 1) != 0) begin
                        if ((d & 32) == 0) model_freeze(c);
                        if ((d & 16) == 0 && m_sp[c] == 0) begin
                            m_sts[c] = (int'(cnt_out[c]) * 128) + (m_acc[c] * 16) + (m_mode[c] * 2) + m_bcd[c];
                            m_sp[c] = 1;
                        end
                    end
                end
            end else if (((d / 16) % 4) == 0) begin
                model_freeze(d / 64);
            end else begin
                m_acc[d / 64] = (d / 16) % 4;
                m_mode[d / 64] = (d / 2) % 8;
                m_bcd[d / 64] = d % 2;
                m_wp[d / 64] = 0;
                m_rp[d / 64] = 0;
            end
        end else if (w != 0) begin
            if (m_acc[a] == 1) begin
                e_stb[a] = 1; e_val[a] = d;
            end else if (m_acc[a] == 2) begin
                e_stb[a] = 1; e_val[a] = d * 256;
            end else if (m_wp[a] != 0) begin
                e_stb[a] = 1; e_val[a] = d * 256 + m_hold[a]; m_wp[a] = 0;
            end else begin
                m_hold[a] = d; m_wp[a] = 1;
            end
        end else if (r != 0 && a != 3) begin
            if (m_sp[a] != 0) m_sp[a] = 0;
            else if (m_lst[a] != 0) m_lst[a] = (m_lst[a] == 3) ? 2 : 0;
            else if (m_acc[a] == 3) m_rp[a] = 1 - m_rp[a];
        end
    endtask

    // one bus cycle: drive at negedge, check rdata, step model at the edge, check outputs after it
    task automatic cyc(input int a, input int w, input int r, input int d, input string tag);
        addr = 2'(a); wr = 1'(w); rd = 1'(r); wdata = 8'(d);
        #1;
        chk(int'(rdata), model_rdata(a, w, r), tag);
        @(posedge clk);
        model_step(a, w, r, d);
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            chk(int'(ld_stb[c]), e_stb[c], tag);
            if (e_stb[c] != 0) chk(int'(ld_val[c*16 +: 16]), e_val[c], tag);
            chk(int'(ch_mode[c*3 +: 3]), m_mode[c], "R12");
        end
        addr = '0; wr = 1'b0; rd = 1'b0; wdata = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        live[0] = 16'h0000; live[1] = 16'hBEEF; live[2] = 16'h0000;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(int'(ld_stb), 0, "R1");
        chk(int'(ch_mode), 9'o333, "R1");
        chk(int'(rdata), 0, "R11");
        // R10: live low/high alternation from reset
        cyc(1, 0, 1, 0, "R1");
        cyc(1, 0, 1, 0, "R10");
        cyc(1, 0, 1, 0, "R10");
        // R4: two-byte reload
        cyc(0, 1, 0, 8'h34, "R4");
        cyc(0, 1, 0, 8'h12, "R4");
        cyc(0, 0, 0, 0, "R4");
        // R2/R3: ch1 low only, mode 2
        cyc(3, 1, 0, 8'h54, "R2");
        chk(int'(ch_mode[5:3]), 2, "R12");
        cyc(1, 1, 0, 8'h77, "R3");
        cyc(1, 0, 1, 0, "R10");
        cyc(1, 0, 1, 0, "R10");
        // R3: ch2 high only, mode 0, bcd 1
        cyc(3, 1, 0, 8'hA1, "R2");
        cyc(2, 1, 0, 8'h5A, "R3");
        cyc(2, 0, 0, 0, "R3");
        live[2] = 16'h6789;
        cyc(2, 0, 1, 0, "R10");
        cyc(2, 0, 1, 0, "R10");
        // R5/R6: freeze ch0, second freeze ignored
        live[0] = 16'h1111;
        cyc(3, 1, 0, 8'h00, "R5");
        live[0] = 16'h2222;
        cyc(3, 1, 0, 8'h00, "R5");
        cyc(0, 0, 1, 0, "R6");
        cyc(0, 0, 1, 0, "R6");
        cyc(0, 0, 1, 0, "R6");
        cyc(0, 0, 1, 0, "R6");
        // R6: high-only freeze on ch2
        live[2] = 16'hABCD;
        cyc(3, 1, 0, 8'h80, "R5");
        live[2] = 16'h0102;
        cyc(2, 0, 1, 0, "R6");
        cyc(2, 0, 1, 0, "R6");
        // R7/R8/R9: read-back all channels, count and status
        live[0] = 16'hC0DE; live[1] = 16'h4455; live[2] = 16'h7788;
        cnt_out = 3'b101;
        cyc(3, 1, 0, 8'hCE, "R7");
        cnt_out = 3'b010;
        live[0] = 16'h0000; live[1] = 16'h0000; live[2] = 16'h0000;
        cyc(3, 1, 0, 8'hE2, "R8");
        cyc(0, 0, 1, 0, "R9");
        cyc(0, 0, 1, 0, "R9");
        cyc(0, 0, 1, 0, "R6");
        cyc(1, 0, 1, 0, "R8");
        cyc(1, 0, 1, 0, "R7");
        cyc(1, 0, 1, 0, "R6");
        cyc(2, 0, 1, 0, "R8");
        cyc(2, 0, 1, 0, "R7");
        // R7: count-only read-back of ch1 and ch2
        live[1] = 16'h9A9B; live[2] = 16'hCDCE;
        cyc(3, 1, 0, 8'hDC, "R7");
        live[1] = 16'h0000; live[2] = 16'h0000;
        cyc(1, 0, 1, 0, "R7");
        cyc(2, 0, 1, 0, "R7");
        cyc(2, 0, 1, 0, "R6");
        // R11: control read returns FF and leaves state
        live[0] = 16'h3344;
        cyc(3, 0, 1, 0, "R11");
        cyc(0, 0, 1, 0, "R11");
        cyc(0, 0, 1, 0, "R11");
        // R2: reprogram drops half-finished two-byte write
        cyc(0, 1, 0, 8'hEE, "R2");
        cyc(3, 1, 0, 8'h32, "R2");
        cyc(0, 1, 0, 8'h01, "R2");
        cyc(0, 1, 0, 8'h02, "R2");
        chk(int'(ld_val[15:0]), 16'h0201, "R4");
        cyc(0, 0, 1, 0, "R10");
        cyc(0, 0, 1, 0, "R10");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule